// File: doc/BRIEF.md
# Supervisor-Call Trap Entry Sequencer

This block carries a processor through entry into one of four supervisor-call traps. When a call is accepted, the two-bit call number picks one of four consecutive trap vectors. The block reads the trap instruction held at that vector. That instruction supplies an operand address, a full-save selector and an offset-enable flag.

The block then writes the caller's status word to the operand address. In full-save mode it also writes the sixteen general registers. Next it reads the new status word and adjusts it. The call's 4-bit field is ORed into the loaded condition code. When the offset-enable flag is set, the same field is added to the loaded program counter.

Every memory access uses a simple request/acknowledge word handshake. A one-cycle done pulse marks completion. The final condition code and program counter are then available on dedicated outputs.

Top module: `call_trap_seq`

## Requirements
- R1: After a call is accepted in idle, the next cycle issues a read at address 0x48 plus the call number (0 to 3). This read fetches the trap instruction.
- R2: The trap instruction word is decoded as follows. Bit 31 is the full-save selector. Bits 30:14 are the operand address. Bit 9 is the offset-enable flag.
- R3: The first write goes to the operand address and carries the saved status word. That word holds the condition code present before the call in bits 31:28, and the calling address plus one (modulo 2^17) in bits 16:0. All other bits are zero.
- R4: With full-save set, register i (0 to 15) is written to operand address + 2 + i. The writes happen in ascending order after the status save, and the data is taken from `reg_rdata` while `reg_sel` equals i.
- R5: With full-save clear, no register is written, and the status save is the only write of the call.
- R6: The new status word is read from operand address + 1. The final condition code is its bits 31:28 ORed with the call field.
- R7: With offset-enable set, the final program counter is the loaded bits 16:0 plus the call field, modulo 2^17. With offset-enable clear, it equals the loaded value.
- R8: A request holds its address, direction and data until `mem_ack`. One acknowledge completes one access, and the sequence advances only on acknowledge.
- R9: `done` is a single-cycle pulse in the cycle after the new status read completes. `final_cc` and `final_pc` are valid from that cycle and hold until the next call completes.
- R10: A call strobe that arrives while the block is busy is ignored.
- R11: After reset, `busy`, `done` and `mem_req` are 0, and `final_cc` and `final_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_valid | input | 1 | Call strobe, accepted when idle |
| call_num | input | 2 | Which of the four calls |
| call_field | input | 4 | Register field of the call instruction |
| cur_cc | input | 4 | Condition code before the call |
| cur_pc | input | 17 | Address of the calling instruction |
| reg_sel | output | 4 | General register index being saved |
| reg_rdata | input | 32 | Contents of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 17 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| final_cc | output | 4 | Modified condition code |
| final_pc | output | 17 | Modified program counter |

## Verification
On every cycle, the assertions check four things:
- the vector read issued after acceptance;
- the ascending register order;
- that requests stay steady until acknowledged, and that done lasts one cycle;
- that the final condition code covers the call field and that latched call inputs stay frozen while busy.

Only the bench scenarios can show the following:
- the contents of the saved status word, including return-address wrap;
- that the simple variant skips the register save;
- the offset addition and its modulo-2^17 wrap;
- that a strobe arriving mid-sequence leaves the result untouched.

// File: rtl/call_trap_seq.sv
module call_trap_seq #(
  parameter int PC_W     = 17,
  parameter int DATA_W   = 32,
  parameter int CC_W     = 4,
  parameter int NREGS    = 16,
  parameter int VEC_BASE = 'h48,
  parameter int AI_BIT   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  input  logic [1:0]        call_num,
  input  logic [CC_W-1:0]   call_field,
  input  logic [CC_W-1:0]   cur_cc,
  input  logic [PC_W-1:0]   cur_pc,
  output logic [$clog2(NREGS)-1:0] reg_sel,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic [CC_W-1:0]   final_cc,
  output logic [PC_W-1:0]   final_pc
);
  localparam int RS_W  = $clog2(NREGS);
  localparam int PAD_W = DATA_W - CC_W - PC_W;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SAVE, S_REGS, S_LOAD, S_DONE} state_t;
  state_t state;

  logic [1:0]      num_q;
  logic [CC_W-1:0] field_q, cc_q;
  logic [PC_W-1:0] ret_q, opa_q;
  logic            full_q, ai_q;
  logic [RS_W-1:0] ridx;

  wire [CC_W-1:0] ld_cc  = mem_rdata[DATA_W-1 -: CC_W];
  wire [PC_W-1:0] ld_pc  = mem_rdata[PC_W-1:0];
  wire [PC_W-1:0] offset = {{(PC_W-CC_W){1'b0}}, field_q};
  wire            step   = mem_req && mem_ack;

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);
  assign mem_req = (state == S_FETCH) || (state == S_SAVE) || (state == S_REGS) || (state == S_LOAD);
  assign mem_we  = (state == S_SAVE) || (state == S_REGS);
  assign reg_sel = ridx;
  assign mem_wdata = (state == S_SAVE) ? {cc_q, {PAD_W{1'b0}}, ret_q} : reg_rdata;

  always_comb begin
    case (state)
      S_FETCH: mem_addr = PC_W'(VEC_BASE) + PC_W'(num_q);
      S_SAVE:  mem_addr = opa_q;
      S_REGS:  mem_addr = opa_q + PC_W'(2) + PC_W'(ridx);
      S_LOAD:  mem_addr = opa_q + PC_W'(1);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      num_q    <= '0;
      field_q  <= '0;
      cc_q     <= '0;
      ret_q    <= '0;
      opa_q    <= '0;
      full_q   <= 1'b0;
      ai_q     <= 1'b0;
      ridx     <= '0;
      final_cc <= '0;
      final_pc <= '0;
    end else begin
      case (state)
        S_IDLE: if (call_valid) begin
          num_q   <= call_num;
          field_q <= call_field;
          cc_q    <= cur_cc;
          ret_q   <= cur_pc + PC_W'(1);
          state   <= S_FETCH;
        end
        S_FETCH: if (step) begin
          full_q <= mem_rdata[DATA_W-1];
          opa_q  <= mem_rdata[DATA_W-2 -: PC_W];
          ai_q   <= mem_rdata[AI_BIT];
          state  <= S_SAVE;
        end
        S_SAVE: if (step) begin
          ridx  <= '0;
          state <= full_q ? S_REGS : S_LOAD;
        end
        S_REGS: if (step) begin
          ridx <= ridx + RS_W'(1);
          if (ridx == RS_W'(NREGS-1)) state <= S_LOAD;
        end
        S_LOAD: if (step) begin
          final_cc <= ld_cc | field_q;
          final_pc <= ai_q ? ld_pc + offset : ld_pc;
          state    <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_vector_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && !busy) |=> (mem_req && !mem_we &&
      mem_addr == PC_W'(VEC_BASE) + PC_W'($past(call_num))));

  p_reg_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REGS && mem_ack && reg_sel != RS_W'(NREGS-1)) |=>
      (state == S_REGS && reg_sel == $past(reg_sel) + RS_W'(1)));

  p_cc_covers_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((final_cc & field_q) == field_q));

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
      $stable(mem_wdata)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(num_q) && $stable(field_q) && $stable(cc_q)));
endmodule

// File: tb/test_call_trap_seq.sv
module test_call_trap_seq;
  logic        clk = 0, rst_n = 0;
  logic        call_valid = 0;
  logic [1:0]  call_num = 0;
  logic [3:0]  call_field = 0, cur_cc = 0;
  logic [16:0] cur_pc = 0;
  logic [3:0]  reg_sel;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [16:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic        busy, done;
  logic [3:0]  final_cc;
  logic [16:0] final_pc;

  int checks = 0, fails = 0;
  int wait_cycles = 0, wcnt = 0, wr_count = 0, rd_count = 0;
  logic [16:0] first_rd;
  logic [31:0] mem [256];

  always #2.5 clk = ~clk;
  assign reg_rdata = 32'hA000_0000 | {28'h0, reg_sel};

  call_trap_seq i_call_trap_seq (
    .clk, .rst_n, .call_valid, .call_num, .call_field, .cur_cc, .cur_pc,
    .reg_sel, .reg_rdata, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_ack, .busy, .done, .final_cc, .final_pc);

  always @(negedge clk) begin
    mem_ack = 0;
    if (mem_req) begin
      if (wcnt < wait_cycles) wcnt++;
      else begin
        wcnt = 0;
        mem_ack = 1;
        if (mem_we) begin
          mem[mem_addr[7:0]] = mem_wdata;
          wr_count++;
        end else begin
          mem_rdata = mem[mem_addr[7:0]];
          if (rd_count == 0) first_rd = mem_addr;
          rd_count++;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] instr(bit full, logic [16:0] opa, bit ai);
    return {full, opa, 4'h0, ai, 9'h0};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_call(string tag, logic [1:0] num, logic [3:0] fld, bit full, bit ai,
                          logic [3:0] cc, logic [16:0] pc, logic [16:0] opa,
                          logic [3:0] new_cc, logic [16:0] new_pc, bit stray);
    int cyc;
    logic [3:0]  exp_cc;
    logic [16:0] exp_pc, ret;
    clear_mem();
    mem[8'h48 + num] = instr(full, opa, ai);
    mem[opa[7:0] + 1] = {new_cc, 11'h0, new_pc};
    wr_count = 0; rd_count = 0;
    @(negedge clk);
    call_valid = 1; call_num = num; call_field = fld; cur_cc = cc; cur_pc = pc;
    @(negedge clk);
    call_valid = 0; cur_cc = ~cc; cur_pc = ~pc;
    if (stray) begin
      repeat (3) @(negedge clk);
      call_valid = 1; call_num = num + 2'd1; call_field = ~fld;
      @(negedge clk);
      call_valid = 0;
    end
    wait_done(cyc);
    exp_cc = new_cc | fld;
    exp_pc = ai ? new_pc + {13'h0, fld} : new_pc;
    ret = pc + 17'd1;
    check({tag, " R9 done seen"}, done, 1);
    check({tag, " R1 vector read"}, first_rd, 17'h48 + num);
    check({tag, " R3 saved status"}, mem[opa[7:0]], {cc, 11'h0, ret});
    check({tag, " R6 final cc"}, final_cc, exp_cc);
    check({tag, " R7 final pc"}, final_pc, exp_pc);
    if (full) begin
      check({tag, " R4 write count"}, wr_count, 17);
      for (int i = 0; i < 16; i++)
        check({tag, " R4 register save"}, mem[opa[7:0] + 2 + i], 32'hA000_0000 | i);
    end else begin
      check({tag, " R5 write count"}, wr_count, 1);
      check({tag, " R5 register area untouched"}, mem[opa[7:0] + 2], 32'hDEAD_0000 | (opa[7:0] + 2));
    end
    check({tag, " R2/R6 reads"}, rd_count, 2);
    @(negedge clk);
    check({tag, " R9 done single pulse"}, done, 0);
    check({tag, " R9 outputs held"}, {final_cc, final_pc}, {exp_cc, exp_pc});
    if (stray) begin
      repeat (3) @(negedge clk);
      check({tag, " R10 no stray restart"}, {busy, mem_req}, 2'b00);
    end
  endtask

  task automatic t_reset();
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 mem_req", mem_req, 0);
    check("R11 final_cc", final_cc, 0);
    check("R11 final_pc", final_pc, 0);
  endtask

  task automatic t_simple();
    run_call("simple", 2'd0, 4'h3, 0, 0, 4'h5, 17'h0100, 17'h00080, 4'h8, 17'h02000, 0);
  endtask

  task automatic t_full_offset();
    run_call("full", 2'd1, 4'hA, 1, 1, 4'h2, 17'h0444, 17'h000A0, 4'h1, 17'h03000, 0);
  endtask

  task automatic t_wrap();
    run_call("wrap", 2'd3, 4'h5, 0, 1, 4'hF, 17'h1FFFF, 17'h000C0, 4'h0, 17'h1FFFE, 0);
  endtask

  task automatic t_slow_mem();
    wait_cycles = 2;
    run_call("slow R8", 2'd2, 4'h6, 1, 1, 4'h9, 17'h00777, 17'h000E0, 4'h9, 17'h00010, 0);
    wait_cycles = 0;
  endtask

  task automatic t_busy_strobe();
    wait_cycles = 1;
    run_call("busy", 2'd2, 4'h4, 1, 0, 4'h3, 17'h01234, 17'h00080, 4'h2, 17'h05555, 1);
    wait_cycles = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_simple();
    t_full_offset();
    t_wrap();
    t_slow_mem();
    t_busy_strobe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule